// File: doc/BRIEF.md
# Key Slot Validate-and-Export Sequencer

This block controls a single key slot and moves its secret to a remote key port in two steps. Software first raises a check request. For one cycle the block shows a busy bit. It then clears that bit by itself and reports the outcome: either a slot-ready flag, or exactly one reason for refusal. A slot is refused when it has not been locked, when the planned transfer would move a different number of bytes than the slot holds, or when no destination address has been set.

When the slot is ready, a second request starts the transfer. The block sends a burst of writes over a request/acknowledge port. Each beat carries 1, 2 or 4 bytes of the key. The address either stays fixed or advances by the beat size. A programmable number of idle cycles separates the beats. At the end the block raises a completion flag. If the receiver answers any beat with an error code, the burst stops at that beat. The block then records which kind of error ended it and still raises the completion flag.

Top module: `key_export_seq`

## Requirements
- R1: A one-cycle pulse on `validate_set` while idle raises `validate_busy` on the next cycle. One cycle later `validate_busy` returns low and the result flags are valid.
- R2: The check passes, setting `slot_ready` with all three refusal flags low, when `slot_locked` is 1, the size rule of R4 holds and `dest_addr_set` is 1.
- R3: A failed check leaves `slot_ready` low and sets exactly one refusal flag. The order of precedence is `err_not_locked`, then `err_size`, then `err_no_addr`.
- R4: Size rule. `cfg_width` code 0, 1 and 2 mean 1, 2 and 4 bytes per beat, and code 3 is invalid. The rule holds only when `cfg_beats` is nonzero and `cfg_beats` times the beat bytes equals 4 times `key_words_loaded`.
- R5: `export_set` while idle with `slot_ready` high starts a burst of `cfg_beats` writes. When the last beat is acknowledged, `export_busy` falls and `export_done` rises in the same cycle.
- R6: Beat i carries key bytes i*B to i*B+B-1, where B is the beat size in bytes. They are packed little-endian into `wr_data`, with byte 0 of the key being `key_data[7:0]`. Bits above B bytes are zero. `wr_addr` and `wr_data` hold steady while a request waits for its acknowledge.
- R7: With `cfg_incr` = 1, beat i goes to `dest_addr` + i*B. With `cfg_incr` = 0, every beat goes to `dest_addr`.
- R8: Between the acknowledge of one beat and the request of the next, `wr_req` stays low for exactly `cfg_delay` cycles.
- R9: An acknowledge with a nonzero `wr_rsp` ends the burst at once. Code 1 sets `err_xfer`, code 2 sets `err_parity` and code 3 sets `err_bus`. `export_done` is set and no further request is issued.
- R10: `export_set` while `slot_ready` is low is ignored. No request is issued and `export_done` keeps its value.
- R11: After reset every status and busy output and `wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| validate_set | input | 1 | Pulse: start a readiness check |
| export_set | input | 1 | Pulse: start the export burst |
| slot_locked | input | 1 | Slot key has been locked against rewrite |
| dest_addr_set | input | 1 | Destination address has been programmed |
| dest_addr | input | ADDR_W | Destination key port base address |
| key_words_loaded | input | KW_W | Number of 32-bit key words written into the slot |
| key_data | input | KEY_WORDS*32 | Slot key contents, byte 0 in the low bits |
| cfg_beats | input | BEATS_W | Number of destination writes |
| cfg_width | input | 2 | Beat size code (0:1 B, 1:2 B, 2:4 B, 3 invalid) |
| cfg_incr | input | 1 | Advance the address after each beat |
| cfg_delay | input | DLY_W | Idle cycles between beats |
| wr_req | output | 1 | Write request to key port |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data, zero above beat size |
| wr_width | output | 2 | Beat size code of current write |
| wr_ack | input | 1 | Write acknowledge |
| wr_rsp | input | 2 | Response code with acknowledge (0 ok, 1 transfer, 2 parity, 3 bus) |
| validate_busy | output | 1 | Self-clearing check request bit |
| export_busy | output | 1 | Self-clearing export request bit |
| slot_ready | output | 1 | Slot passed its check |
| err_not_locked | output | 1 | Check refused: slot not locked |
| err_size | output | 1 | Check refused: transfer size mismatch |
| err_no_addr | output | 1 | Check refused: no destination address |
| export_done | output | 1 | Export finished |
| err_xfer | output | 1 | Export ended by transfer error response |
| err_parity | output | 1 | Export ended by integrity error response |
| err_bus | output | 1 | Export ended by bus error response |

## Verification
The hardest case to reach from the ports is a response error that stops a burst partway through, after some beats have already landed. The bench answers the port with a responder that counts beats and returns a chosen nonzero code on one chosen beat. This lets it confirm that the beats before the error were logged normally and that no beat follows it. The same responder logs the idle cycles between beats. Timing under nonzero delays is therefore checked beat by beat rather than only by total duration.

// File: rtl/kes_pkg.sv
package kes_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_BEAT  = 2'd2,
    ST_GAP   = 2'd3
  } kes_state_e;

  localparam logic [1:0] RSP_OK     = 2'd0;
  localparam logic [1:0] RSP_XFER   = 2'd1;
  localparam logic [1:0] RSP_PARITY = 2'd2;
  localparam logic [1:0] RSP_BUS    = 2'd3;

  // bytes carried by one beat for a width code; 0 marks the invalid code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      2'd2:    width_bytes = 3'd4;
      default: width_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/kes_precheck.sv
module kes_precheck #(
  parameter int KW_W    = 4,
  parameter int BEATS_W = 6
) (
  input  logic               locked,
  input  logic               addr_set,
  input  logic [KW_W-1:0]    words,
  input  logic [BEATS_W-1:0] beats,
  input  logic [1:0]         width,
  output logic               pass,
  output logic               no_lock,
  output logic               bad_size,
  output logic               no_addr
);
  import kes_pkg::*;

  localparam int PW = BEATS_W + KW_W + 4;

  logic [PW-1:0] beat_total;
  logic [PW-1:0] slot_total;
  logic          size_ok;

  always_comb begin
    beat_total = PW'(beats) * PW'(width_bytes(width));
    slot_total = PW'(words) << 2;
    size_ok    = (beats != '0) && (width_bytes(width) != 3'd0) &&
                 (beat_total == slot_total);
  end

  // precedence: lock first, then size, then address
  always_comb begin
    no_lock  = !locked;
    bad_size = locked && !size_ok;
    no_addr  = locked && size_ok && !addr_set;
    pass     = locked && size_ok && addr_set;
  end

endmodule

// File: rtl/kes_beat_gen.sv
module kes_beat_gen #(
  parameter int ADDR_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int BEATS_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    advance,
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic [1:0]              width_in,
  input  logic                    incr_in,
  input  logic [KEY_WORDS*32-1:0] key_data,
  output logic [BEATS_W-1:0]      beat_idx,
  output logic [ADDR_W-1:0]       beat_addr,
  output logic [31:0]             beat_data,
  output logic [1:0]              beat_width
);
  import kes_pkg::*;

  localparam int KEY_BITS = KEY_WORDS * 32;
  localparam int OFF_W    = BEATS_W + 2;
  localparam int SH_W     = OFF_W + 3;

  logic [BEATS_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [1:0]         wid_q, wid_d;
  logic               inc_q, inc_d;
  logic               cfg_en;
  logic               pos_en;

  logic [OFF_W-1:0]    byte_off;
  logic [KEY_BITS-1:0] shifted;

  always_comb begin
    cfg_en = start;
    pos_en = start || advance;
    wid_d  = width_in;
    inc_d  = incr_in;
    if (start) begin
      idx_d  = '0;
      addr_d = base_addr;
    end else begin
      idx_d  = idx_q + 1'b1;
      addr_d = inc_q ? addr_q + ADDR_W'(width_bytes(wid_q)) : addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
      wid_q  <= '0;
      inc_q  <= 1'b0;
    end else begin
      if (pos_en) begin
        idx_q  <= idx_d;
        addr_q <= addr_d;
      end
      if (cfg_en) begin
        wid_q <= wid_d;
        inc_q <= inc_d;
      end
    end
  end

  always_comb begin
    byte_off = OFF_W'(idx_q) << wid_q;
    shifted  = key_data >> {SH_W'(byte_off), 3'b000};
    case (wid_q)
      2'd0:    beat_data = {24'd0, shifted[7:0]};
      2'd1:    beat_data = {16'd0, shifted[15:0]};
      default: beat_data = shifted[31:0];
    endcase
  end

  assign beat_idx   = idx_q;
  assign beat_addr  = addr_q;
  assign beat_width = wid_q;

endmodule

// File: rtl/kes_gap_timer.sv
module kes_gap_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] value,
  output logic             expire
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? value : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == DLY_W'(1));

endmodule

// File: rtl/key_export_seq.sv
module key_export_seq #(
  parameter  int ADDR_W    = 32,
  parameter  int KEY_WORDS = 8,
  parameter  int BEATS_W   = 6,
  parameter  int DLY_W     = 4,
  localparam int KW_W      = $clog2(KEY_WORDS + 1),
  localparam int KEY_BITS  = KEY_WORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                validate_set,
  input  logic                export_set,
  input  logic                slot_locked,
  input  logic                dest_addr_set,
  input  logic [ADDR_W-1:0]   dest_addr,
  input  logic [KW_W-1:0]     key_words_loaded,
  input  logic [KEY_BITS-1:0] key_data,
  input  logic [BEATS_W-1:0]  cfg_beats,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_incr,
  input  logic [DLY_W-1:0]    cfg_delay,
  output logic                wr_req,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [31:0]         wr_data,
  output logic [1:0]          wr_width,
  input  logic                wr_ack,
  input  logic [1:0]          wr_rsp,
  output logic                validate_busy,
  output logic                export_busy,
  output logic                slot_ready,
  output logic                err_not_locked,
  output logic                err_size,
  output logic                err_no_addr,
  output logic                export_done,
  output logic                err_xfer,
  output logic                err_parity,
  output logic                err_bus
);
  import kes_pkg::*;

  kes_state_e state_q, state_d;

  // check result flags: ready, not-locked, size, no-address
  logic [3:0] chk_q, chk_d;
  logic       chk_en;
  // export flags: done, transfer, parity, bus
  logic [3:0] xpt_q, xpt_d;
  logic       xpt_en;

  logic [BEATS_W-1:0] beats_q;
  logic [DLY_W-1:0]   dly_q;
  logic               snap_en;

  logic pc_pass, pc_nolock, pc_size, pc_noaddr;
  logic bg_start, bg_adv;
  logic [BEATS_W-1:0] beat_idx;
  logic tm_load, tm_expire;
  logic last_beat;

  kes_precheck #(.KW_W(KW_W), .BEATS_W(BEATS_W)) u_precheck (
    .locked   (slot_locked),
    .addr_set (dest_addr_set),
    .words    (key_words_loaded),
    .beats    (cfg_beats),
    .width    (cfg_width),
    .pass     (pc_pass),
    .no_lock  (pc_nolock),
    .bad_size (pc_size),
    .no_addr  (pc_noaddr)
  );

  kes_beat_gen #(.ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS), .BEATS_W(BEATS_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (bg_start),
    .advance    (bg_adv),
    .base_addr  (dest_addr),
    .width_in   (cfg_width),
    .incr_in    (cfg_incr),
    .key_data   (key_data),
    .beat_idx   (beat_idx),
    .beat_addr  (wr_addr),
    .beat_data  (wr_data),
    .beat_width (wr_width)
  );

  kes_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tm_load),
    .value  (dly_q),
    .expire (tm_expire)
  );

  assign last_beat = (beat_idx == beats_q - 1'b1);

  always_comb begin
    state_d  = state_q;
    chk_en   = 1'b0;
    chk_d    = chk_q;
    xpt_en   = 1'b0;
    xpt_d    = xpt_q;
    snap_en  = 1'b0;
    bg_start = 1'b0;
    bg_adv   = 1'b0;
    tm_load  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (validate_set) begin
          state_d = ST_CHECK;
          chk_en  = 1'b1;
          chk_d   = 4'b0000;
        end else if (export_set && chk_q[0]) begin
          state_d  = ST_BEAT;
          xpt_en   = 1'b1;
          xpt_d    = 4'b0000;
          snap_en  = 1'b1;
          bg_start = 1'b1;
        end
      end
      ST_CHECK: begin
        state_d = ST_IDLE;
        chk_en  = 1'b1;
        chk_d   = {pc_noaddr, pc_size, pc_nolock, pc_pass};
      end
      ST_BEAT: begin
        if (wr_ack) begin
          if (wr_rsp != RSP_OK) begin
            state_d = ST_IDLE;
            xpt_en  = 1'b1;
            xpt_d   = {wr_rsp == RSP_BUS, wr_rsp == RSP_PARITY,
                       wr_rsp == RSP_XFER, 1'b1};
          end else if (last_beat) begin
            state_d = ST_IDLE;
            xpt_en  = 1'b1;
            xpt_d   = 4'b0001;
          end else if (dly_q == '0) begin
            bg_adv = 1'b1;
          end else begin
            state_d = ST_GAP;
            bg_adv  = 1'b1;
            tm_load = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tm_expire) state_d = ST_BEAT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chk_q   <= '0;
      xpt_q   <= '0;
      beats_q <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      if (chk_en) chk_q <= chk_d;
      if (xpt_en) xpt_q <= xpt_d;
      if (snap_en) begin
        beats_q <= cfg_beats;
        dly_q   <= cfg_delay;
      end
    end
  end

  assign wr_req         = (state_q == ST_BEAT);
  assign validate_busy  = (state_q == ST_CHECK);
  assign export_busy    = (state_q == ST_BEAT) || (state_q == ST_GAP);
  assign slot_ready     = chk_q[0];
  assign err_not_locked = chk_q[1];
  assign err_size       = chk_q[2];
  assign err_no_addr    = chk_q[3];
  assign export_done    = xpt_q[0];
  assign err_xfer       = xpt_q[1];
  assign err_parity     = xpt_q[2];
  assign err_bus        = xpt_q[3];

endmodule

// File: rtl/kes_checker.sv
module kes_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              validate_set,
  input logic              export_set,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_ack,
  input logic [1:0]        wr_rsp,
  input logic              validate_busy,
  input logic              export_busy,
  input logic              slot_ready,
  input logic              err_not_locked,
  input logic              err_size,
  input logic              err_no_addr,
  input logic              export_done
);

  // R1
  vld_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(validate_busy) |=> !validate_busy);

  // R3
  vld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(validate_busy) |->
      $countones({slot_ready, err_not_locked, err_size, err_no_addr}) == 1);

  // R5
  req_in_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> export_busy);

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(export_done) |-> $fell(export_busy));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && (wr_rsp != 2'd0) |=> !wr_req && !export_busy && export_done);

  // R10
  export_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    export_set && !validate_set && !slot_ready && !export_busy && !validate_busy
      |=> !export_busy && !wr_req);

endmodule

bind key_export_seq kes_checker #(.ADDR_W(ADDR_W)) u_kes_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .validate_set   (validate_set),
  .export_set     (export_set),
  .wr_req         (wr_req),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .wr_ack         (wr_ack),
  .wr_rsp         (wr_rsp),
  .validate_busy  (validate_busy),
  .export_busy    (export_busy),
  .slot_ready     (slot_ready),
  .err_not_locked (err_not_locked),
  .err_size       (err_size),
  .err_no_addr    (err_no_addr),
  .export_done    (export_done)
);

// File: tb/tb_key_export_seq.sv
`timescale 1ns/1ps
module tb_key_export_seq;
  localparam int ADDR_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int BEATS_W   = 6;
  localparam int DLY_W     = 4;
  localparam int KW_W      = $clog2(KEY_WORDS + 1);
  localparam int KEY_BITS  = KEY_WORDS * 32;

  // {locked, addr_set, words[4], beats[6], width[2], expect[2]}
  // expect: 0 ready, 1 not locked, 2 size, 3 no address
  localparam logic [15:0] VEC [10] = '{
    {1'b1, 1'b1, 4'd8, 6'd32, 2'd0, 2'd0},
    {1'b1, 1'b1, 4'd8, 6'd8,  2'd2, 2'd0},
    {1'b0, 1'b1, 4'd8, 6'd8,  2'd2, 2'd1},
    {1'b0, 1'b0, 4'd3, 6'd1,  2'd0, 2'd1},
    {1'b1, 1'b1, 4'd8, 6'd7,  2'd2, 2'd2},
    {1'b1, 1'b0, 4'd8, 6'd7,  2'd2, 2'd2},
    {1'b1, 1'b0, 4'd8, 6'd8,  2'd2, 2'd3},
    {1'b1, 1'b1, 4'd4, 6'd8,  2'd1, 2'd0},
    {1'b1, 1'b1, 4'd4, 6'd4,  2'd3, 2'd2},
    {1'b1, 1'b1, 4'd0, 6'd0,  2'd2, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic validate_set, export_set, slot_locked, dest_addr_set;
  logic [ADDR_W-1:0]   dest_addr;
  logic [KW_W-1:0]     key_words_loaded;
  logic [KEY_BITS-1:0] key_data;
  logic [BEATS_W-1:0]  cfg_beats;
  logic [1:0]          cfg_width;
  logic                cfg_incr;
  logic [DLY_W-1:0]    cfg_delay;
  logic                wr_req;
  logic [ADDR_W-1:0]   wr_addr;
  logic [31:0]         wr_data;
  logic [1:0]          wr_width;
  logic                wr_ack;
  logic [1:0]          wr_rsp;
  logic validate_busy, export_busy, slot_ready, err_not_locked, err_size, err_no_addr;
  logic export_done, err_xfer, err_parity, err_bus;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // responder state
  logic        log_clr;
  int          err_beat;
  logic [1:0]  err_code;
  int          nbeats;
  int          idle;
  logic [31:0] addr_log [64];
  logic [31:0] data_log [64];
  int          gap_log  [64];

  always #4 clk = ~clk;

  key_export_seq #(.ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS), .BEATS_W(BEATS_W),
                   .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .validate_set(validate_set), .export_set(export_set),
    .slot_locked(slot_locked), .dest_addr_set(dest_addr_set), .dest_addr(dest_addr),
    .key_words_loaded(key_words_loaded), .key_data(key_data), .cfg_beats(cfg_beats),
    .cfg_width(cfg_width), .cfg_incr(cfg_incr), .cfg_delay(cfg_delay),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_width(wr_width),
    .wr_ack(wr_ack), .wr_rsp(wr_rsp), .validate_busy(validate_busy),
    .export_busy(export_busy), .slot_ready(slot_ready), .err_not_locked(err_not_locked),
    .err_size(err_size), .err_no_addr(err_no_addr), .export_done(export_done),
    .err_xfer(err_xfer), .err_parity(err_parity), .err_bus(err_bus)
  );

  always @(negedge clk) begin
    if (!rst_n || log_clr) begin
      wr_ack <= 1'b0; wr_rsp <= 2'd0; nbeats <= 0; idle <= 0;
    end else if (wr_ack) begin
      wr_ack <= 1'b0; wr_rsp <= 2'd0;
      if (!wr_req) idle <= idle + 1;
    end else if (wr_req) begin
      if (nbeats < 64) begin
        addr_log[nbeats] <= wr_addr;
        data_log[nbeats] <= wr_data;
        gap_log[nbeats]  <= idle;
      end
      idle   <= 0;
      wr_ack <= 1'b1;
      wr_rsp <= (nbeats == err_beat) ? err_code : 2'd0;
      nbeats <= nbeats + 1;
    end else begin
      idle <= idle + 1;
    end
  end

  task automatic summary_and_finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cycles);
      summary_and_finish();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] key_byte(input int j);
    return 8'(j * 13 + 5);
  endfunction

  task automatic run_validate(input logic lk, input logic as, input logic [3:0] kw,
                              input logic [5:0] bt, input logic [1:0] w,
                              input logic [1:0] exp, input string tag);
    @(negedge clk);
    slot_locked = lk; dest_addr_set = as; key_words_loaded = KW_W'(kw);
    cfg_beats = bt; cfg_width = w; validate_set = 1'b1;
    @(negedge clk);
    validate_set = 1'b0;
    chk({"R1 busy ", tag}, {63'd0, validate_busy}, 64'd1);
    @(negedge clk);
    chk({"R1 clear ", tag}, {63'd0, validate_busy}, 64'd0);
    // R2 R3 R4: result flags {noaddr,size,nolock,ready}
    chk({"R2/R3/R4 flags ", tag},
        {60'd0, err_no_addr, err_size, err_not_locked, slot_ready},
        64'(4'b0001 << exp));
  endtask

  task automatic run_export(input logic [31:0] base, input logic [1:0] w,
                            input logic [5:0] bt, input logic inc, input logic [3:0] dl,
                            input int eb, input logic [1:0] ec, input string tag);
    int bb;
    int expn;
    int guard;
    logic [31:0] ed;
    bb = 1 << w;
    dest_addr = base; cfg_incr = inc; cfg_delay = DLY_W'(dl);
    run_validate(1'b1, 1'b1, 4'((32'(bt) * bb) / 4), bt, w, 2'd0, tag);
    err_beat = eb; err_code = ec;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0; export_set = 1'b1;
    @(negedge clk); export_set = 1'b0;
    chk({"R5 started ", tag}, {62'd0, export_busy, export_done}, 64'b10);
    guard = 0;
    while (export_busy && guard < 5000) begin
      @(negedge clk); guard++;
    end
    expn = (eb < int'(bt)) ? eb + 1 : int'(bt);
    chk({"R5 beat count ", tag}, 64'(nbeats), 64'(expn));
    chk({"R5 done ", tag}, {63'd0, export_done}, 64'd1);
    // R9 error flags {bus,parity,xfer}
    chk({"R9 error flags ", tag}, {61'd0, err_bus, err_parity, err_xfer},
        (eb < int'(bt)) ? 64'(3'b001 << (ec - 1)) : 64'd0);
    for (int i = 0; i < expn && i < 64; i++) begin
      ed = '0;
      for (int b = 0; b < bb; b++) ed[b*8 +: 8] = key_byte(i * bb + b);
      chk($sformatf("R6 data beat %0d %s", i, tag), 64'(data_log[i]), 64'(ed));
      chk($sformatf("R7 addr beat %0d %s", i, tag), 64'(addr_log[i]),
          64'(inc ? base + 32'(i * bb) : base));
      if (i > 0)
        chk($sformatf("R8 gap beat %0d %s", i, tag), 64'(gap_log[i]), 64'(dl));
    end
    repeat (3) @(negedge clk);
    chk({"R9 no request after end ", tag}, 64'(nbeats), 64'(expn));
  endtask

  initial begin
    rst_n = 1'b0; validate_set = 0; export_set = 0; slot_locked = 0; dest_addr_set = 0;
    dest_addr = '0; key_words_loaded = '0; cfg_beats = '0; cfg_width = '0;
    cfg_incr = 0; cfg_delay = '0; log_clr = 0; err_beat = 1000; err_code = 2'd0;
    for (int j = 0; j < KEY_BITS / 8; j++) key_data[j*8 +: 8] = key_byte(j);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs",
        {54'd0, wr_req, validate_busy, export_busy, slot_ready, err_not_locked,
         err_size, err_no_addr, export_done, err_xfer, err_parity, err_bus}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: readiness checks
    for (int v = 0; v < 10; v++) begin
      run_validate(VEC[v][15], VEC[v][14], VEC[v][13:10], VEC[v][9:4], VEC[v][3:2],
                   VEC[v][1:0], $sformatf("vec%0d", v));
    end

    // directed exports
    run_export(32'h0000_1000, 2'd2, 6'd8,  1'b1, 4'd0, 1000, 2'd0, "w4 incr nodelay");
    run_export(32'h0000_2002, 2'd1, 6'd16, 1'b1, 4'd2, 1000, 2'd0, "w2 incr delay2");
    run_export(32'h0000_3000, 2'd0, 6'd32, 1'b0, 4'd1, 1000, 2'd0, "w1 fixed delay1");
    run_export(32'h0000_4000, 2'd2, 6'd8,  1'b1, 4'd3, 1,    2'd1, "xfer err beat1");
    run_export(32'h0000_5000, 2'd2, 6'd8,  1'b1, 4'd0, 2,    2'd2, "parity err beat2");
    run_export(32'h0000_6000, 2'd1, 6'd16, 1'b0, 4'd0, 0,    2'd3, "bus err beat0");

    // R10: export while not ready is ignored
    run_validate(1'b0, 1'b1, 4'd8, 6'd8, 2'd2, 2'd1, "R10 prep");
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0; export_set = 1'b1;
    @(negedge clk); export_set = 1'b0;
    chk("R10 no export busy", {63'd0, export_busy}, 64'd0);
    repeat (4) @(negedge clk);
    chk("R10 no writes", 64'(nbeats), 64'd0);
    chk("R10 done unchanged", {63'd0, export_done}, 64'd1);

    summary_and_finish();
  end

endmodule